// File: doc/BRIEF.md
# Shared-Pool Virtual-Channel Input Buffer

This block is the flit store of one router input port. Rather than giving every virtual channel a private FIFO of fixed depth, it holds all flits in one pool of `V*K` slots and threads the flits of each virtual channel together as a linked chain. Because slots are handed out one flit at a time, a port can run a few deep channels or many shallow ones. With the defaults (V = 4, K = 4) it ranges from 4 channels each holding 4 flits to 16 channels each holding 1 flit. The number of channels is not fixed at design time.

Virtual channels are handed out from a free list. The lowest channel identifiers are reserved as escape channels for deadlock avoidance, and only an explicit escape request can obtain one. The upstream side writes flits tagged with a channel identifier. The switch side reads the oldest flit of a chosen channel. When the flit marked as a packet tail is read and leaves its chain empty, the channel goes back to the free list and a one-cycle release notice is sent upstream, in the same way as a credit return.

Top module: `shared_vc_buffer`

## Requirements
- R1: After reset every channel reads empty with occupancy 0, no release notice is raised, and every channel is unallocated, so a write to any channel is rejected.
- R2: An ordinary allocation request (`alloc_esc` = 0) is granted in the same cycle with the lowest-numbered free channel whose identifier is at least `NUM_ESC`. The channel counts as allocated from the next clock edge.
- R3: An escape request (`alloc_esc` = 1) is granted the lowest free channel below `NUM_ESC`. An ordinary request is never given an escape channel. When no suitable channel is free, `alloc_gnt` stays low.
- R4: An accepted write adds the flit at the end of its channel's chain. The channel's occupancy rises by one and its empty flag falls after the clock edge.
- R5: A read of a non-empty channel raises `rd_ok` in the same cycle and shows that channel's oldest flit on `rd_data` and `rd_tail`. Each channel gives back its flits in write order even when writes to several channels are interleaved in the shared pool.
- R6: One channel may fill every slot of the pool. A write is rejected (`wr_err` = 1) when no slot is free at the start of the cycle, and the rejected flit is not stored.
- R7: A write to an unallocated channel is rejected with `wr_err` = 1. No occupancy or chain changes.
- R8: A read of an empty channel gives `rd_ok` = 0 and changes no state.
- R9: A read of a tail flit that leaves its chain empty raises `rel_valid` for exactly one cycle after the edge, with `rel_vc` naming the channel. That channel is then free for allocation again.
- R10: A read and a write in the same cycle both take effect, on different channels or on the same one. This holds even when the chain holds a single flit, in which case the new flit becomes the head. The slot freed by the read can be used only from the next cycle.
- R11: Every identifier from 0 to `V*K-1` can be active at once, each channel holding at least one flit. After that, further allocation requests are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request a free virtual channel |
| alloc_esc | input | 1 | Request targets the escape class |
| alloc_gnt | output | 1 | Request granted this cycle |
| alloc_vc | output | VCW | Granted channel identifier |
| wr_valid | input | 1 | Flit write strobe |
| wr_vc | input | VCW | Channel of the written flit |
| wr_data | input | FLIT_W | Flit payload |
| wr_tail | input | 1 | Flit closes its packet |
| wr_err | output | 1 | Write rejected this cycle |
| rd_valid | input | 1 | Read strobe |
| rd_vc | input | VCW | Channel to read |
| rd_ok | output | 1 | Read performed this cycle |
| rd_data | output | FLIT_W | Oldest flit payload of `rd_vc` |
| rd_tail | output | 1 | Tail mark of that flit |
| vc_empty | output | V*K | One bit per channel, set when its chain is empty |
| vc_count | output | V*K*CNTW | Occupancy per channel, channel n at bits n*CNTW upward |
| rel_valid | output | 1 | Channel release notice for upstream |
| rel_vc | output | VCW | Released channel identifier |

## Verification
Two functions can meet in one cycle: a read that hands a slot back to the pool, and a write that takes one. The bench provokes this on different channels, on the same channel when its chain holds a single flit, and while the pool is completely full. In that last case the write must still be refused. Each case is judged by a scoreboard with one queue per channel: the flits that come out must match the queue in order, the occupancy of every channel must match the queue length, and the release notice must appear exactly when a tail read empties a queue that received no write in the same cycle.

// File: rtl/uvb_pkg.sv
package uvb_pkg;

  // index width for n items, never below one bit
  function automatic int idx_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // counter width able to hold 0..n
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction

  // classification of a read, brought out as a named event
  typedef enum logic [1:0] {
    RD_IDLE    = 2'd0,
    RD_EMPTY   = 2'd1,
    RD_POP     = 2'd2,
    RD_RELEASE = 2'd3
  } rd_kind_e;

endpackage

// File: rtl/uvb_first_set.sv
module uvb_first_set #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  mask,
  output logic          found,
  output logic [IW-1:0] idx
);

  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/uvb_slot_pool.sv
module uvb_slot_pool
  import uvb_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int FLIT_W = 16,
  localparam int SW    = idx_w(SLOTS),
  localparam int CNTW  = cnt_w(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [FLIT_W-1:0] take_data,
  input  logic              take_tail,
  input  logic              put,
  input  logic [SW-1:0]     put_idx,
  input  logic              link_en,
  input  logic [SW-1:0]     link_idx,
  input  logic [SW-1:0]     rd_idx,
  output logic              pick_valid,
  output logic [SW-1:0]     pick_idx,
  output logic [CNTW-1:0]   free_cnt,
  output logic [FLIT_W-1:0] rd_data,
  output logic              rd_tail,
  output logic [SW-1:0]     rd_next
);

  logic [SLOTS-1:0]  free_map;
  logic [SLOTS-1:0]  free_nxt;
  logic [FLIT_W-1:0] data_q [SLOTS];
  logic              tail_q [SLOTS];
  logic [SW-1:0]     next_q [SLOTS];

  function automatic logic [CNTW-1:0] popcnt(input logic [SLOTS-1:0] m);
    logic [CNTW-1:0] s;
    s = '0;
    for (int i = 0; i < SLOTS; i++) s = s + CNTW'(m[i]);
    return s;
  endfunction

  uvb_first_set #(.W(SLOTS), .IW(SW)) u_pick (
    .mask  (free_map),
    .found (pick_valid),
    .idx   (pick_idx)
  );

  assign free_cnt = popcnt(free_map);

  always_comb begin
    free_nxt = free_map;
    if (take) free_nxt[pick_idx] = 1'b0;
    if (put)  free_nxt[put_idx]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_map <= '1;
    else        free_map <= free_nxt;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      data_q[pick_idx] <= take_data;
      tail_q[pick_idx] <= take_tail;
    end
    if (link_en) next_q[link_idx] <= pick_idx;
  end

  assign rd_data = data_q[rd_idx];
  assign rd_tail = tail_q[rd_idx];
  assign rd_next = next_q[rd_idx];

  AST_PUT_WAS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    put |-> !free_map[put_idx]); // R10

endmodule

// File: rtl/uvb_vc_table.sv
module uvb_vc_table
  import uvb_pkg::*;
#(
  parameter int NVC   = 16,
  parameter int SLOTS = 16,
  localparam int VCW  = idx_w(NVC),
  localparam int SW   = idx_w(SLOTS),
  localparam int CNTW = cnt_w(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_take,
  input  logic [VCW-1:0]      alloc_id,
  input  logic                rel_en,
  input  logic                wr_en,
  input  logic [VCW-1:0]      wr_vc,
  input  logic [SW-1:0]       new_slot,
  input  logic                rd_en,
  input  logic [VCW-1:0]      rd_vc,
  input  logic [SW-1:0]       head_next,
  output logic [NVC-1:0]      alloc_map,
  output logic [SW-1:0]       head_rd,
  output logic [SW-1:0]       tail_wr,
  output logic [CNTW-1:0]     cnt_rd,
  output logic [CNTW-1:0]     cnt_wr,
  output logic [NVC-1:0]      empty,
  output logic [NVC*CNTW-1:0] cnt_flat
);

  logic [SW-1:0]   head_arr [NVC];
  logic [SW-1:0]   tail_arr [NVC];
  logic [CNTW-1:0] cnt_arr  [NVC];
  logic            own_arr  [NVC];

  for (genvar v = 0; v < NVC; v++) begin : g_vc
    logic [SW-1:0]   h;
    logic [SW-1:0]   t;
    logic [CNTW-1:0] c;
    logic            a;
    logic            inc;
    logic            dec;

    assign inc = wr_en && (wr_vc == VCW'(v));
    assign dec = rd_en && (rd_vc == VCW'(v));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        h <= '0;
        t <= '0;
        c <= '0;
        a <= 1'b0;
      end else begin
        c <= c + CNTW'(inc) - CNTW'(dec);
        if (inc) t <= new_slot;
        if (inc && ((c == '0) || ((c == CNTW'(1)) && dec))) h <= new_slot;
        else if (dec)                                        h <= head_next;
        if (rel_en && dec)                             a <= 1'b0;
        else if (alloc_take && (alloc_id == VCW'(v)))  a <= 1'b1;
      end
    end

    assign head_arr[v] = h;
    assign tail_arr[v] = t;
    assign cnt_arr[v]  = c;
    assign own_arr[v]  = a;

    AST_IDLE_VC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !a |-> (c == '0)); // R7
  end

  always_comb begin
    for (int v = 0; v < NVC; v++) begin
      alloc_map[v]                 = own_arr[v];
      empty[v]                     = (cnt_arr[v] == '0);
      cnt_flat[v*CNTW +: CNTW]     = cnt_arr[v];
    end
  end

  assign head_rd = head_arr[rd_vc];
  assign tail_wr = tail_arr[wr_vc];
  assign cnt_rd  = cnt_arr[rd_vc];
  assign cnt_wr  = cnt_arr[wr_vc];

endmodule

// File: rtl/shared_vc_buffer.sv
module shared_vc_buffer
  import uvb_pkg::*;
#(
  parameter int V       = 4,
  parameter int K       = 4,
  parameter int NUM_ESC = 1,
  parameter int FLIT_W  = 16,
  localparam int NVC    = V * K,
  localparam int SLOTS  = V * K,
  localparam int VCW    = idx_w(NVC),
  localparam int SW     = idx_w(SLOTS),
  localparam int CNTW   = cnt_w(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_req,
  input  logic                alloc_esc,
  output logic                alloc_gnt,
  output logic [VCW-1:0]      alloc_vc,
  input  logic                wr_valid,
  input  logic [VCW-1:0]      wr_vc,
  input  logic [FLIT_W-1:0]   wr_data,
  input  logic                wr_tail,
  output logic                wr_err,
  input  logic                rd_valid,
  input  logic [VCW-1:0]      rd_vc,
  output logic                rd_ok,
  output logic [FLIT_W-1:0]   rd_data,
  output logic                rd_tail,
  output logic [NVC-1:0]      vc_empty,
  output logic [NVC*CNTW-1:0] vc_count,
  output logic                rel_valid,
  output logic [VCW-1:0]      rel_vc
);

  // named internal events
  logic            wr_acc;
  logic            same_vc_rw;
  logic            release_now;
  logic            link_en;
  rd_kind_e        rd_kind;

  logic [NVC-1:0]  alloc_map;
  logic [NVC-1:0]  cand_mask;
  logic [NVC-1:0]  esc_mask;
  logic            cand_found;
  logic [SW-1:0]   head_rd;
  logic [SW-1:0]   tail_wr;
  logic [CNTW-1:0] cnt_rd;
  logic [CNTW-1:0] cnt_wr;
  logic            pick_valid;
  logic [SW-1:0]   pick_idx;
  logic [CNTW-1:0] free_cnt;
  logic [SW-1:0]   head_next;

  function automatic int total_held(input logic [NVC*CNTW-1:0] flat);
    int s;
    s = 0;
    for (int v = 0; v < NVC; v++) s += int'(flat[v*CNTW +: CNTW]);
    return s;
  endfunction

  // escape class mask: identifiers below NUM_ESC
  for (genvar v = 0; v < NVC; v++) begin : g_esc
    assign esc_mask[v] = (v < NUM_ESC);
  end

  assign cand_mask = ~alloc_map & (alloc_esc ? esc_mask : ~esc_mask);

  uvb_first_set #(.W(NVC), .IW(VCW)) u_vc_pick (
    .mask  (cand_mask),
    .found (cand_found),
    .idx   (alloc_vc)
  );

  assign alloc_gnt = alloc_req && cand_found;

  // write side
  assign wr_acc  = wr_valid && alloc_map[wr_vc] && pick_valid;
  assign wr_err  = wr_valid && !wr_acc;
  assign link_en = wr_acc && (cnt_wr != '0);

  // read side
  assign rd_ok       = rd_valid && (cnt_rd != '0);
  assign same_vc_rw  = wr_acc && rd_ok && (wr_vc == rd_vc);
  assign release_now = rd_ok && rd_tail && (cnt_rd == CNTW'(1)) && !same_vc_rw;

  always_comb begin
    if (!rd_valid)        rd_kind = RD_IDLE;
    else if (!rd_ok)      rd_kind = RD_EMPTY;
    else if (release_now) rd_kind = RD_RELEASE;
    else                  rd_kind = RD_POP;
  end

  uvb_slot_pool #(.SLOTS(SLOTS), .FLIT_W(FLIT_W)) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (wr_acc),
    .take_data  (wr_data),
    .take_tail  (wr_tail),
    .put        (rd_ok),
    .put_idx    (head_rd),
    .link_en    (link_en),
    .link_idx   (tail_wr),
    .rd_idx     (head_rd),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx),
    .free_cnt   (free_cnt),
    .rd_data    (rd_data),
    .rd_tail    (rd_tail),
    .rd_next    (head_next)
  );

  uvb_vc_table #(.NVC(NVC), .SLOTS(SLOTS)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_take (alloc_gnt),
    .alloc_id   (alloc_vc),
    .rel_en     (rd_kind == RD_RELEASE),
    .wr_en      (wr_acc),
    .wr_vc      (wr_vc),
    .new_slot   (pick_idx),
    .rd_en      (rd_ok),
    .rd_vc      (rd_vc),
    .head_next  (head_next),
    .alloc_map  (alloc_map),
    .head_rd    (head_rd),
    .tail_wr    (tail_wr),
    .cnt_rd     (cnt_rd),
    .cnt_wr     (cnt_wr),
    .empty      (vc_empty),
    .cnt_flat   (vc_count)
  );

  // release notice towards upstream
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_valid <= 1'b0;
      rel_vc    <= '0;
    end else begin
      rel_valid <= release_now;
      rel_vc    <= rd_vc;
    end
  end

  AST_ESC_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt && !alloc_esc) |-> (int'(alloc_vc) >= NUM_ESC)); // R3
  AST_POOL_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(free_cnt) + total_held(vc_count)) == SLOTS); // R6
  AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (free_cnt == '0)) |-> wr_err); // R6
  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !rd_ok) |=> (free_cnt == $past(free_cnt))); // R7
  AST_REL_FREED: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (vc_empty[rel_vc] && !alloc_map[rel_vc])); // R9

endmodule

// File: tb/tb_shared_vc_buffer.sv
`timescale 1ns/1ps
module tb_shared_vc_buffer;

  localparam int V      = 4;
  localparam int K      = 4;
  localparam int NESC   = 1;
  localparam int FW     = 16;
  localparam int NVC    = V * K;
  localparam int SLOTS  = V * K;
  localparam int VCW    = $clog2(NVC);
  localparam int CNTW   = $clog2(SLOTS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 0, alloc_esc = 0;
  logic alloc_gnt;
  logic [VCW-1:0] alloc_vc;
  logic wr_valid = 0, wr_tail = 0;
  logic [VCW-1:0] wr_vc = '0;
  logic [FW-1:0] wr_data = '0;
  logic wr_err;
  logic rd_valid = 0;
  logic [VCW-1:0] rd_vc = '0;
  logic rd_ok, rd_tail;
  logic [FW-1:0] rd_data;
  logic [NVC-1:0] vc_empty;
  logic [NVC*CNTW-1:0] vc_count;
  logic rel_valid;
  logic [VCW-1:0] rel_vc;

  always #2.5 clk = ~clk;

  shared_vc_buffer #(.V(V), .K(K), .NUM_ESC(NESC), .FLIT_W(FW)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_esc(alloc_esc), .alloc_gnt(alloc_gnt), .alloc_vc(alloc_vc),
    .wr_valid(wr_valid), .wr_vc(wr_vc), .wr_data(wr_data), .wr_tail(wr_tail), .wr_err(wr_err),
    .rd_valid(rd_valid), .rd_vc(rd_vc), .rd_ok(rd_ok), .rd_data(rd_data), .rd_tail(rd_tail),
    .vc_empty(vc_empty), .vc_count(vc_count), .rel_valid(rel_valid), .rel_vc(rel_vc)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // scoreboard: one expected queue per channel, {tail, data}
  bit             m_alloc [NVC];
  logic [FW:0]    sb_q    [NVC][$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int held();
    int s = 0;
    for (int v = 0; v < NVC; v++) s += sb_q[v].size();
    return s;
  endfunction

  // driver + monitor for one cycle of traffic
  task automatic step(input bit a_req, input bit a_esc,
                      input bit w_v, input int w_c, input logic [FW-1:0] w_d, input bit w_t,
                      input bit r_v, input int r_c, input string tag);
    bit e_gnt = 0, e_err, e_rok, e_rel = 0;
    int e_vc = 0, lo, hi;
    logic [FW:0] item = '0;
    @(negedge clk);
    alloc_req = a_req; alloc_esc = a_esc;
    wr_valid = w_v; wr_vc = VCW'(w_c); wr_data = w_d; wr_tail = w_t;
    rd_valid = r_v; rd_vc = VCW'(r_c);
    lo = a_esc ? 0 : NESC;
    hi = a_esc ? NESC : NVC;
    for (int v = hi - 1; v >= lo; v--) if (!m_alloc[v]) begin e_gnt = a_req; e_vc = v; end
    e_err = w_v && (!m_alloc[w_c] || held() >= SLOTS);
    e_rok = r_v && (sb_q[r_c].size() > 0);
    #1;
    if (a_req) begin
      check(alloc_gnt === e_gnt, tag, "alloc_gnt", alloc_gnt, e_gnt);
      if (e_gnt) check(int'(alloc_vc) == e_vc, tag, "alloc_vc", alloc_vc, e_vc);
    end
    if (w_v) check(wr_err === e_err, tag, "wr_err", wr_err, e_err);
    if (r_v) begin
      check(rd_ok === e_rok, tag, "rd_ok", rd_ok, e_rok);
      if (e_rok) check({rd_tail, rd_data} === sb_q[r_c][0], tag, "rd flit",
                       {rd_tail, rd_data}, sb_q[r_c][0]);
    end
    if (e_rok) item = sb_q[r_c].pop_front();
    if (w_v && !e_err) sb_q[w_c].push_back({w_t, w_d});
    if (e_rok && item[FW] && sb_q[r_c].size() == 0) e_rel = 1;
    if (e_gnt) m_alloc[e_vc] = 1;
    if (e_rel) m_alloc[r_c] = 0;
    @(posedge clk); #1;
    alloc_req = 0; wr_valid = 0; rd_valid = 0;
    check(rel_valid === e_rel, e_rel ? "R9" : tag, "rel_valid", rel_valid, e_rel);
    if (e_rel) check(int'(rel_vc) == r_c, "R9", "rel_vc", rel_vc, r_c);
    for (int v = 0; v < NVC; v++) begin
      if (int'(vc_count[v*CNTW +: CNTW]) != sb_q[v].size() ||
          vc_empty[v] !== (sb_q[v].size() == 0)) begin
        check(0, "R4", $sformatf("vc%0d count", v), vc_count[v*CNTW +: CNTW], sb_q[v].size());
      end
    end
    n_tests++;
  endtask

  task automatic alloc(input bit esc, input string tag);
    step(1, esc, 0, 0, '0, 0, 0, 0, tag);
  endtask
  task automatic wr(input int c, input logic [FW-1:0] d, input bit t, input string tag);
    step(0, 0, 1, c, d, t, 0, 0, tag);
  endtask
  task automatic rd(input int c, input string tag);
    step(0, 0, 0, 0, '0, 0, 1, c, tag);
  endtask

  initial begin
    for (int v = 0; v < NVC; v++) m_alloc[v] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check(vc_empty === '1, "R1", "vc_empty", vc_empty, '1);
    check(vc_count === '0, "R1", "vc_count", vc_count, 0);
    check(rel_valid === 1'b0, "R1", "rel_valid", rel_valid, 0);
    wr(1, 16'h0bad, 0, "R1");

    // R2 / R3 allocation classes
    alloc(0, "R2");
    alloc(0, "R2");
    alloc(1, "R3");
    alloc(1, "R3");

    // R7 write to an unallocated channel
    wr(5, 16'hdead, 1, "R7");

    // R4 / R5 interleaved chains
    wr(1, 16'h1001, 0, "R4");
    wr(2, 16'h2001, 0, "R4");
    wr(1, 16'h1002, 0, "R5");
    wr(2, 16'h2002, 1, "R5");
    wr(1, 16'h1003, 1, "R5");
    rd(3, "R8");
    rd(0, "R8");
    rd(2, "R5");
    rd(1, "R5");
    rd(2, "R9");
    rd(1, "R5");
    rd(1, "R9");
    alloc(0, "R9");
    alloc(0, "R2");

    // R6 one channel takes the whole pool
    for (int i = 0; i < SLOTS; i++) wr(1, 16'h3000 + 16'(i), i == SLOTS - 1, "R6");
    wr(2, 16'h4000, 0, "R6");
    // R10 read while full: write still refused
    step(0, 0, 1, 2, 16'h4001, 0, 1, 1, "R10");
    // R10 read and write on different channels, both succeed
    step(0, 0, 1, 2, 16'h4002, 0, 1, 1, "R10");
    for (int i = 0; i < SLOTS - 2; i++) step(0, 0, i < 2, 2, 16'h4003 + 16'(i), 0, 1, 1, "R10");
    // drain channel 2 to one flit, then read and write it together
    rd(2, "R5");
    rd(2, "R5");
    step(0, 0, 1, 2, 16'h4100, 0, 1, 2, "R10");
    step(0, 0, 1, 2, 16'h4101, 1, 1, 2, "R10");
    rd(2, "R9");

    // R11 every identifier active at once
    for (int i = 0; i < NVC - 1; i++) alloc(0, "R11");
    alloc(0, "R11");
    alloc(1, "R11");
    for (int v = 0; v < NVC; v++) wr(v, 16'h5000 + 16'(v), 1, "R11");
    for (int v = NVC - 1; v >= 0; v--) rd(v, "R11");
    alloc(0, "R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule